// File: doc/BRIEF.md
# Serial Configuration Frame Checker

This block parses a bit-serial configuration stream one bit at a time, taking a bit only when the bit-valid strobe is high. It hunts for a fixed header byte and captures the 24-bit length count that follows. It then splits the rest of the stream into frames: one identification frame, then address and data frames. It checks the framing, the identification code and a per-frame XOR checksum. Data-frame payload bits are passed out one at a time with a strobe, so that a later stage can write them into configuration storage.

Frames are delimited by a run of at least eight ones followed by a two-bit start code. The first frame must be the identification frame. Every data frame ends with a two-bit continuation code that either closes the stream or announces more frames. On the first detected fault, the parser raises one of three error flags and then ignores all input until reset.

Top module: `cfg_stream_chk`

## Requirements
- R1: After reset, frame_type is 0, frame_addr, length_cnt, data_stb, len_met and stream_done are 0, and all three error flags are 0.
- R2: Bits before the header byte 8'b1111_0010 (first bit = MSB) are ignored. The 24 bits after the header are captured MSB first and appear on length_cnt, which then holds until reset.
- R3: After the length field, and after each address-frame checksum and each 10 continuation code, a frame starts at the first 0 seen after at least eight consecutive ones. A 0 that follows fewer than eight ones sets align_err.
- R4: The first frame is the identification frame. Its first 16 bits must be 0101_1111_1111_1111, or align_err is set. Then come 44 reserved bits and a 20-bit part code, MSB first. If the part code differs from PART_ID, id_err is set on its last bit. frame_type shows 1 from the second frame bit on.
- R5: An address frame starts with 00 and carries a 14-bit address, MSB first. frame_addr takes the address on its last bit. frame_type shows 2.
- R6: A data frame starts with 01 and has 6 pad bits, then DATA_BITS payload bits. Each payload bit appears on data_bit with a one-cycle data_stb, in stream order. frame_type shows 3.
- R7: Each frame body is followed by an 8-bit checksum, MSB first. It equals the XOR of the body's bytes, with bytes formed MSB first from the first start-code bit. A mismatch sets sum_err on the eighth checksum bit.
- R8: After each data-frame checksum, two bits follow. 00 sets stream_done, after which input has no effect. 10 returns to stop-bit hunting. 01 or 11 sets align_err.
- R9: len_met pulses for one cycle after the valid bit that makes the number of bits taken since the end of the length field equal to length_cnt.
- R10: After any error flag rises, it and the other flags stay fixed, and data_stb, frame_addr and stream_done do not change until reset.
- R11: Cycles with ser_vld low have no effect, whatever ser_bit is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_bit | input | 1 | Serial stream bit |
| ser_vld | input | 1 | ser_bit is valid this cycle |
| frame_type | output | 2 | 0 none, 1 identification, 2 address, 3 data |
| frame_addr | output | ADDR_W | Last address captured |
| data_bit | output | 1 | Payload bit |
| data_stb | output | 1 | data_bit is valid |
| length_cnt | output | LEN_W | Captured length count |
| len_met | output | 1 | Length count reached (one-cycle pulse) |
| stream_done | output | 1 | Closing code seen |
| id_err | output | 1 | Part code mismatch |
| align_err | output | 1 | Framing or stop-run fault |
| sum_err | output | 1 | Checksum mismatch |

## Verification
The hardest case to reach is the length-met pulse landing exactly on a chosen bit deep inside the frames. The length field must be known before the frames that come after it are built. The bench therefore builds each stream with a placeholder length, picks a random target among the bits that follow, and patches the field before playing the stream with random idle gaps. The same randomised streams vary the stop-run lengths, the number of address and data pairs and the payload values, while directed streams corrupt exactly one field each.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;
   typedef enum logic [1:0] {
      FT_NONE = 2'd0,
      FT_ID   = 2'd1,
      FT_ADDR = 2'd2,
      FT_DATA = 2'd3
   } ftype_e;

   typedef enum logic [2:0] {
      S_HUNT, S_GAP, S_BODY, S_SUM, S_POST, S_DONE, S_ERR
   } pstate_e;

   localparam logic [7:0]  HDR_BYTE = 8'b1111_0010;
   localparam logic [15:0] ID_HDR   = 16'b0101_1111_1111_1111;
   localparam int          ID_LEN   = 80;
   localparam int          PAD_END  = 8;
endpackage

// File: rtl/cfg_hdr_sync.sv
module cfg_hdr_sync
   import cfg_stream_pkg::*;
#(
   parameter int LEN_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld,
   input  logic             din,
   output logic             fin,
   output logic             locked,
   output logic [LEN_W-1:0] len
);
   localparam int CW = $clog2(LEN_W);

   logic [6:0]    sh;
   logic          coll;
   logic [CW-1:0] cnt;
   logic [7:0]    nxt;

   assign nxt = {sh, din};
   assign fin = coll && vld && (cnt == CW'(LEN_W-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh     <= '0;
         coll   <= 1'b0;
         cnt    <= '0;
         locked <= 1'b0;
         len    <= '0;
      end else if (vld) begin
         if (!coll && !locked) begin
            sh  <= nxt[6:0];
            cnt <= '0;
            if (nxt == HDR_BYTE) coll <= 1'b1;
         end else if (coll) begin
            len <= {len[LEN_W-2:0], din};
            cnt <= cnt + 1'b1;
            if (fin) begin
               coll   <= 1'b0;
               locked <= 1'b1;
            end
         end
      end
   end

   AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> ($stable(len) && locked)); // R2
endmodule

// File: rtl/cfg_xsum.sv
module cfg_xsum #(
   parameter int W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 en,
   input  logic                 din,
   input  logic [$clog2(W)-1:0] idx,
   output logic [W-1:0]         acc
);
   localparam int IW = $clog2(W);

   for (genvar i = 0; i < W; i++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            acc[i] <= 1'b0;
         else if (clr)
            acc[i] <= 1'b0;
         else if (en && (idx == IW'(W-1-i)))
            acc[i] <= acc[i] ^ din;
      end
   end
endmodule

// File: rtl/cfg_len_mon.sv
module cfg_len_mon #(
   parameter int LEN_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act,
   input  logic             vld,
   input  logic [LEN_W-1:0] len,
   output logic             met
);
   logic [LEN_W-1:0] cnt;
   logic [LEN_W-1:0] cnt_nx;

   assign cnt_nx = cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         met <= 1'b0;
      end else begin
         met <= act && vld && (cnt_nx == len);
         if (act && vld) cnt <= cnt_nx;
      end
   end

   AST_MET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      met |=> !met); // R9
endmodule

// File: rtl/cfg_stream_chk.sv
module cfg_stream_chk
   import cfg_stream_pkg::*;
#(
   parameter int              DATA_BITS = 32,
   parameter int              ADDR_W    = 14,
   parameter int              ID_W      = 20,
   parameter int              LEN_W     = 24,
   parameter logic [ID_W-1:0] PART_ID   = 20'h4A3C1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_bit,
   input  logic              ser_vld,
   output logic [1:0]        frame_type,
   output logic [ADDR_W-1:0] frame_addr,
   output logic              data_bit,
   output logic              data_stb,
   output logic [LEN_W-1:0]  length_cnt,
   output logic              len_met,
   output logic              stream_done,
   output logic              id_err,
   output logic              align_err,
   output logic              sum_err
);
   localparam int ADDR_LEN = 2 + ADDR_W;
   localparam int DATA_LEN = PAD_END + DATA_BITS;
   localparam int MAX_A    = (ID_LEN > ADDR_LEN) ? ID_LEN : ADDR_LEN;
   localparam int MAX_LEN  = (MAX_A > DATA_LEN) ? MAX_A : DATA_LEN;
   localparam int POS_W    = $clog2(MAX_LEN);
   localparam int ID_START = ID_LEN - ID_W;
   localparam logic [POS_W-1:0] ID_END   = POS_W'(ID_LEN - 1);
   localparam logic [POS_W-1:0] ADDR_END = POS_W'(ADDR_LEN - 1);
   localparam logic [POS_W-1:0] DATA_END = POS_W'(DATA_LEN - 1);
   localparam logic [3:0]       RUN_MAX  = 4'd8;

   if (DATA_BITS < 8 || (DATA_BITS % 8) != 0) begin : g_bad_data
      $error("DATA_BITS must be a positive multiple of 8");
   end
   if (ADDR_W < 6 || (ADDR_LEN % 8) != 0) begin : g_bad_addr
      $error("ADDR_W plus the start code must fill whole bytes");
   end
   if (ID_W < 2 || ID_W > 64) begin : g_bad_id
      $error("ID_W must lie in 2..64");
   end
   if (LEN_W < 2) begin : g_bad_len
      $error("LEN_W must be at least 2");
   end

   pstate_e          st;
   ftype_e           kind_q;
   ftype_e           kind1;
   logic [3:0]       run;
   logic [POS_W-1:0] pos;
   logic             id_pend;
   logic [ID_W-2:0]  id_sh;
   logic [ADDR_W-2:0] addr_sh;
   logic [ID_W-1:0]  id_word;
   logic [ADDR_W-1:0] addr_word;
   logic [2:0]       sk;
   logic             bad;
   logic             mis;
   logic             p0;
   logic             pstep;
   logic             hdr_fin;
   logic             hdr_locked;
   logic             ck_clr;
   logic             ck_en;
   logic [7:0]       acc;
   logic             cnt_act;

   cfg_hdr_sync #(.LEN_W(LEN_W)) u_hdr (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld    (ser_vld),
      .din    (ser_bit),
      .fin    (hdr_fin),
      .locked (hdr_locked),
      .len    (length_cnt)
   );

   assign ck_clr = (st == S_GAP) && ser_vld && !ser_bit && (run == RUN_MAX);
   assign ck_en  = (st == S_BODY) && ser_vld;

   cfg_xsum #(.W(8)) u_xsum (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ck_clr),
      .en    (ck_en),
      .din   (ser_bit),
      .idx   (pos[2:0]),
      .acc   (acc)
   );

   assign cnt_act = hdr_locked && (st != S_DONE) && (st != S_ERR);

   cfg_len_mon #(.LEN_W(LEN_W)) u_len (
      .clk   (clk),
      .rst_n (rst_n),
      .act   (cnt_act),
      .vld   (ser_vld),
      .len   (length_cnt),
      .met   (len_met)
   );

   always_comb begin
      if (id_pend)      kind1 = FT_ID;
      else if (ser_bit) kind1 = FT_DATA;
      else              kind1 = FT_ADDR;
   end

   assign id_word   = {id_sh, ser_bit};
   assign addr_word = {addr_sh, ser_bit};
   assign mis       = ser_bit != acc[3'd7 - sk];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= S_HUNT;
         kind_q      <= FT_NONE;
         frame_type  <= FT_NONE;
         run         <= '0;
         pos         <= '0;
         id_pend     <= 1'b1;
         id_sh       <= '0;
         addr_sh     <= '0;
         frame_addr  <= '0;
         data_bit    <= 1'b0;
         data_stb    <= 1'b0;
         sk          <= '0;
         bad         <= 1'b0;
         p0          <= 1'b0;
         pstep       <= 1'b0;
         stream_done <= 1'b0;
         id_err      <= 1'b0;
         align_err   <= 1'b0;
         sum_err     <= 1'b0;
      end else begin
         data_stb <= 1'b0;
         if (ser_vld) begin
            unique case (st)
               S_HUNT: begin
                  if (hdr_fin) begin
                     st  <= S_GAP;
                     run <= '0;
                  end
               end
               S_GAP: begin
                  if (ser_bit) begin
                     if (run != RUN_MAX) run <= run + 1'b1;
                  end else if (run != RUN_MAX) begin
                     align_err <= 1'b1;
                     st        <= S_ERR;
                  end else begin
                     st  <= S_BODY;
                     pos <= POS_W'(1);
                  end
               end
               S_BODY: begin
                  pos <= pos + 1'b1;
                  if (pos == POS_W'(1)) begin
                     kind_q     <= kind1;
                     frame_type <= kind1;
                     if (id_pend && !ser_bit) begin
                        align_err <= 1'b1;
                        st        <= S_ERR;
                     end
                  end else begin
                     unique case (kind_q)
                        FT_ID: begin
                           if (pos < POS_W'(16) &&
                               ser_bit != ID_HDR[4'd15 - pos[3:0]]) begin
                              align_err <= 1'b1;
                              st        <= S_ERR;
                           end
                           if (pos >= POS_W'(ID_START)) id_sh <= id_word[ID_W-2:0];
                           if (pos == ID_END) begin
                              if (id_word != PART_ID) begin
                                 id_err <= 1'b1;
                                 st     <= S_ERR;
                              end else begin
                                 id_pend <= 1'b0;
                                 st      <= S_SUM;
                                 sk      <= '0;
                                 bad     <= 1'b0;
                              end
                           end
                        end
                        FT_ADDR: begin
                           addr_sh <= addr_word[ADDR_W-2:0];
                           if (pos == ADDR_END) begin
                              frame_addr <= addr_word;
                              st         <= S_SUM;
                              sk         <= '0;
                              bad        <= 1'b0;
                           end
                        end
                        FT_DATA: begin
                           if (pos >= POS_W'(PAD_END)) begin
                              data_bit <= ser_bit;
                              data_stb <= 1'b1;
                           end
                           if (pos == DATA_END) begin
                              st  <= S_SUM;
                              sk  <= '0;
                              bad <= 1'b0;
                           end
                        end
                        default: ;
                     endcase
                  end
               end
               S_SUM: begin
                  sk  <= sk + 1'b1;
                  bad <= bad | mis;
                  if (sk == 3'd7) begin
                     if (bad || mis) begin
                        sum_err <= 1'b1;
                        st      <= S_ERR;
                     end else if (kind_q == FT_DATA) begin
                        st    <= S_POST;
                        pstep <= 1'b0;
                     end else begin
                        st  <= S_GAP;
                        run <= '0;
                     end
                  end
               end
               S_POST: begin
                  if (!pstep) begin
                     p0    <= ser_bit;
                     pstep <= 1'b1;
                  end else begin
                     pstep <= 1'b0;
                     unique case ({p0, ser_bit})
                        2'b00: begin
                           stream_done <= 1'b1;
                           st          <= S_DONE;
                        end
                        2'b10: begin
                           st  <= S_GAP;
                           run <= '0;
                        end
                        default: begin
                           align_err <= 1'b1;
                           st        <= S_ERR;
                        end
                     endcase
                  end
               end
               S_DONE, S_ERR: ;
               default: st <= S_ERR;
            endcase
         end
      end
   end

   AST_ERR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({id_err, align_err, sum_err})); // R10
   AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (id_err || align_err || sum_err) |=>
         ($stable({id_err, align_err, sum_err, frame_addr, stream_done}) && !data_stb)); // R10
   AST_STB_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      data_stb |-> (frame_type == FT_DATA)); // R6
   AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      stream_done |-> !(id_err || align_err || sum_err)); // R8
   AST_NO_STB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ser_vld |=> !data_stb); // R11
endmodule

// File: tb/sim_cfg_stream_chk.sv
module sim_cfg_stream_chk;
   localparam int          DB  = 32;
   localparam int          AW  = 14;
   localparam int          IW  = 20;
   localparam int          LW  = 24;
   localparam logic [19:0] PID = 20'h4A3C1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ser_bit = 1'b0;
   logic          ser_vld = 1'b0;
   logic [1:0]    frame_type;
   logic [AW-1:0] frame_addr;
   logic          data_bit;
   logic          data_stb;
   logic [LW-1:0] length_cnt;
   logic          len_met;
   logic          stream_done;
   logic          id_err;
   logic          align_err;
   logic          sum_err;

   cfg_stream_chk #(.DATA_BITS(DB), .ADDR_W(AW), .ID_W(IW), .LEN_W(LW), .PART_ID(PID)) u0 (
      .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .ser_vld(ser_vld),
      .frame_type(frame_type), .frame_addr(frame_addr), .data_bit(data_bit),
      .data_stb(data_stb), .length_cnt(length_cnt), .len_met(len_met),
      .stream_done(stream_done), .id_err(id_err), .align_err(align_err),
      .sum_err(sum_err)
   );

   always #5 clk = ~clk;

   int   checks = 0;
   int   errors = 0;
   logic stream[$];
   logic fb[$];
   logic exp_data[$];
   logic got_data[$];
   int   nproc;
   int   lm_cnt;
   int   lm_at;
   int   pre;

   always @(posedge clk) begin
      if (!rst_n) nproc <= 0;
      else if (ser_vld) nproc <= nproc + 1;
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         got_data.delete();
         lm_cnt <= 0;
         lm_at  <= 0;
      end else begin
         if (data_stb) got_data.push_back(data_bit);
         if (len_met) begin
            lm_cnt <= lm_cnt + 1;
            lm_at  <= nproc;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic put(input logic [63:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) fb.push_back(v[i]);
   endtask

   task automatic close_frame(input bit corrupt);
      logic [7:0] s;
      s = '0;
      for (int i = 0; i < fb.size(); i++) s[7 - (i % 8)] ^= fb[i];
      if (corrupt) s[0] = ~s[0];
      for (int i = 0; i < fb.size(); i++) stream.push_back(fb[i]);
      for (int i = 7; i >= 0; i--) stream.push_back(s[i]);
      fb.delete();
   endtask

   task automatic ones(input int n);
      for (int i = 0; i < n; i++) stream.push_back(1'b1);
   endtask

   task automatic header();
      int z;
      z = 8 + int'($urandom % 5);
      for (int i = 0; i < z; i++) stream.push_back(1'b0);
      for (int i = 7; i >= 0; i--) stream.push_back(logic'(8'hF2 >> i));
      for (int i = 0; i < LW; i++) stream.push_back(1'b0);
      pre = stream.size();
   endtask

   task automatic set_len(input logic [LW-1:0] l);
      for (int i = 0; i < LW; i++) stream[pre - LW + i] = l[LW - 1 - i];
   endtask

   task automatic id_frame(input logic [19:0] id, input bit corrupt);
      put(64'h5FFF, 16);
      put(64'h0, 44);
      put({44'h0, id}, 20);
      close_frame(corrupt);
   endtask

   task automatic addr_frame(input logic [AW-1:0] a, input bit corrupt);
      put(64'h0, 2);
      put({50'h0, a}, AW);
      close_frame(corrupt);
   endtask

   task automatic data_frame(input logic [DB-1:0] d, input bit corrupt);
      put(64'h1, 2);
      put(64'h0, 6);
      put({32'h0, d}, DB);
      for (int i = DB - 1; i >= 0; i--) exp_data.push_back(d[i]);
      close_frame(corrupt);
   endtask

   task automatic post(input logic [1:0] p);
      stream.push_back(p[1]);
      stream.push_back(p[0]);
   endtask

   task automatic play();
      for (int i = 0; i < stream.size(); i++) begin
         @(negedge clk);
         ser_bit = stream[i];
         ser_vld = 1'b1;
         @(negedge clk);
         ser_vld = 1'b0;
         ser_bit = logic'($urandom);
         repeat ($urandom % 3) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      stream.delete();
   endtask

   task automatic do_reset();
      ser_vld = 1'b0;
      rst_n   = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      exp_data.delete();
      @(negedge clk);
   endtask

   task automatic cmp_data(input string req);
      int bad;
      bad = 0;
      chk(got_data.size() == exp_data.size(), req, got_data.size(), exp_data.size());
      if (got_data.size() == exp_data.size())
         for (int i = 0; i < got_data.size(); i++) if (got_data[i] !== exp_data[i]) bad++;
      chk(bad == 0, req, bad, 0);
   endtask

   task automatic errs_are(input logic [2:0] e, input string req);
      chk({id_err, align_err, sum_err} === e, req, {id_err, align_err, sum_err}, e);
   endtask

   initial begin
      logic [AW-1:0] la;
      logic [LW-1:0] L;
      int            nd;
      void'($urandom(32'd20240601));

      // R1 reset state
      do_reset();
      chk(frame_type == 2'd0, "R1 frame_type", frame_type, 0);
      chk(frame_addr == '0 && length_cnt == '0, "R1 addr/len", {frame_addr, length_cnt}, 0);
      chk(!data_stb && !len_met && !stream_done, "R1 strobes", {data_stb, len_met, stream_done}, 0);
      errs_are(3'b000, "R1 flags");

      // Main directed stream: R2 R5 R6 R7 R8 R9 R11
      header();
      ones(8);
      id_frame(PID, 1'b0);
      ones(8);
      addr_frame(14'h2A5C, 1'b0);
      ones(9);
      data_frame(32'hDEADBEEF, 1'b0);
      post(2'b10);
      ones(8);
      addr_frame(14'h0013, 1'b0);
      ones(8);
      data_frame(32'h0F0F00FF, 1'b0);
      post(2'b00);
      L = LW'(stream.size() - pre - 3);
      set_len(L);
      nd = pre;
      play();
      chk(length_cnt == L, "R2 length capture", length_cnt, L);
      chk(stream_done == 1'b1, "R8 closing code", stream_done, 1);
      errs_are(3'b000, "R7 good checksums");
      chk(frame_addr == 14'h0013, "R5 address", frame_addr, 14'h0013);
      chk(frame_type == 2'd3, "R6 frame_type", frame_type, 3);
      cmp_data("R6 payload");
      chk(lm_cnt == 1 && lm_at == nd + int'(L), "R9 length met", lm_at, nd + int'(L));

      // R8 input after closing code has no effect
      ones(8);
      addr_frame(14'h1111, 1'b0);
      ones(8);
      data_frame(32'h12345678, 1'b0);
      play();
      chk(frame_addr == 14'h0013, "R8 ignored after done", frame_addr, 14'h0013);
      chk(got_data.size() == 2 * DB, "R8 no data after done", got_data.size(), 2 * DB);

      // Constrained random streams: R3 R5 R6 R7 R9 R11
      for (int t = 0; t < 6; t++) begin
         int np;
         do_reset();
         header();
         ones(8 + int'($urandom % 4));
         id_frame(PID, 1'b0);
         np = 1 + int'($urandom % 3);
         for (int p = 0; p < np; p++) begin
            ones(8 + int'($urandom % 4));
            la = AW'($urandom);
            addr_frame(la, 1'b0);
            ones(8 + int'($urandom % 3));
            data_frame(DB'($urandom), 1'b0);
            post((p == np - 1) ? 2'b00 : 2'b10);
         end
         L = LW'($urandom_range(stream.size() - pre, 1));
         set_len(L);
         nd = pre;
         play();
         chk(stream_done && !id_err && !align_err && !sum_err, "R3 random stream",
             {stream_done, id_err, align_err, sum_err}, 4'b1000);
         chk(frame_addr == la, "R5 random address", frame_addr, la);
         cmp_data("R6 random payload");
         chk(lm_cnt == 1 && lm_at == nd + int'(L), "R9 random length met", lm_at, nd + int'(L));
      end

      // R3 short stop run before the first frame, then R10 lock
      do_reset();
      header();
      set_len(24'hFFFFFF);
      ones(5);
      id_frame(PID, 1'b0);
      play();
      errs_are(3'b010, "R3 short run");
      ones(8);
      data_frame(32'hA5A5A5A5, 1'b0);
      play();
      errs_are(3'b010, "R10 flag held");
      chk(got_data.size() == 0 && !stream_done, "R10 no output after error", got_data.size(), 0);

      // R4 part code mismatch
      do_reset();
      header();
      set_len(24'hFFFFFF);
      ones(8);
      id_frame(PID ^ 20'h00400, 1'b0);
      play();
      errs_are(3'b100, "R4 part code");
      chk(frame_type == 2'd1, "R4 frame_type", frame_type, 1);

      // R4 first frame without the identification header
      do_reset();
      header();
      set_len(24'hFFFFFF);
      ones(8);
      addr_frame(14'h0ABC, 1'b0);
      play();
      errs_are(3'b010, "R4 header pattern");

      // R7 corrupted address checksum
      do_reset();
      header();
      set_len(24'hFFFFFF);
      ones(8);
      id_frame(PID, 1'b0);
      ones(8);
      addr_frame(14'h1555, 1'b1);
      play();
      errs_are(3'b001, "R7 bad checksum");
      chk(frame_addr == 14'h1555 && frame_type == 2'd2, "R5 address before checksum",
          frame_addr, 14'h1555);

      // R8 illegal continuation code
      do_reset();
      header();
      set_len(24'hFFFFFF);
      ones(8);
      id_frame(PID, 1'b0);
      ones(8);
      addr_frame(14'h0042, 1'b0);
      ones(8);
      data_frame(32'hCAFE0001, 1'b0);
      post(2'b01);
      play();
      errs_are(3'b010, "R8 bad continuation");
      cmp_data("R6 payload before fault");

      // R3 seven ones between frames
      do_reset();
      header();
      set_len(24'hFFFFFF);
      ones(8);
      id_frame(PID, 1'b0);
      ones(8);
      addr_frame(14'h0042, 1'b0);
      ones(7);
      data_frame(32'h00000001, 1'b0);
      play();
      errs_are(3'b010, "R3 seven ones");
      chk(got_data.size() == 0, "R3 no payload", got_data.size(), 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule